// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Controller

This block turns one internal access request into a single cycle on a multiplexed external memory bus. A request gives a 20-bit address, a read/write flag, two byte enables and 16 bits of write data. The block then runs the access on the external pins as a fixed sequence. First the address is put on the pins while the latch-enable pulse is high. Next the latch-enable falls with the address still held. Then the read or write strobe is asserted for a parameterised number of cycles. Then the strobe is released, and after that the block returns to idle.

On the external side the low address bits share pins with data. A width input picks an 8-bit or a 16-bit bus. A style input picks, for a 16-bit bus only, between two strobe schemes:
- a common write strobe with a byte-high-enable;
- separate even-byte and odd-byte write strobes.

The block presents an output-enable for the shared pins and leaves the pads, chip selects and wait states to its neighbours. A request for a word at an odd address on a 16-bit bus is refused with an error response, and no bus cycle is run for it.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset the bus is idle: `bus_ale`=0, `bus_rd_n`=`bus_wr_n`=`bus_bhe_n`=1, `bus_ad_oe`=0, `bus_a`=0, `bus_dh_out`=0, `req_ready`=1 and `resp_valid`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Cycle numbers count from that edge. With DATA_CYC data cycles, cycle 1 has `bus_ale`=1. Cycle 2 has `bus_ale`=0 and no strobe. Cycles 3 to DATA_CYC+2 have the strobe asserted. Cycle DATA_CYC+3 has the strobe released and `resp_valid`=1 with `resp_err`=0. Cycle DATA_CYC+4 is idle with `req_ready`=1.
- R3: The full request address is on `bus_a` in cycles 1 and 2, so it does not change across the falling edge of `bus_ale`. `bus_ad_oe` is 1 in both cycles.
- R4: On an 8-bit bus (`cfg_narrow`=1), `bus_a[7:0]` carry write data byte `req_wdata[7:0]` in the data and release cycles of a write. `bus_a[19:8]` keep the address. `bus_dh_out` stays 0.
- R5: On a 16-bit bus (`cfg_narrow`=0), `bus_a[0]` keeps A0. In the data and release cycles of a write, `bus_a[8:1]` carry `req_wdata[7:0]` and `bus_dh_out` carries `req_wdata[15:8]`. `bus_a[19:9]` keep the address.
- R6: On a 16-bit bus, `req_be`=2'b11 asks for a word and any other value asks for a byte whose lane is address bit 0 (0 = even, 1 = odd). The odd lane is used by an odd byte or by a word. In the write/byte-high style (`cfg_split`=0), `bus_wr_n` is 0 during the data cycles of a write. `bus_bhe_n` is 0 from cycle 1 to the release cycle when the odd lane is used.
- R7: In the split style (`cfg_split`=1, 16-bit bus), `bus_wr_n` acts as the even-byte write strobe and `bus_bhe_n` as the odd-byte write strobe. Each is 0 during the data cycles of a write that uses its lane, so a word drives both. A read leaves both at 1.
- R8: With `cfg_narrow`=1 the block uses the write/byte-high style whatever `cfg_split` is. `bus_bhe_n` stays 1 for the whole access.
- R9: For a read, `bus_rd_n` is 0 in the data cycles and `bus_wr_n` stays 1. `bus_ad_oe` is 0 from cycle 3 through the release cycle. The read data is sampled on the edge that ends the last data cycle, as {`bus_dh_in`, `bus_sh_in[8:1]`} on a 16-bit bus or {8'h00, `bus_sh_in[7:0]`} on an 8-bit bus. It is presented on `resp_rdata` in the release cycle.
- R10: A 16-bit-bus request with `req_be`=2'b11 and an odd address gives `resp_valid`=1 and `resp_err`=1 in cycle 1 with no latch-enable and no strobe. The block is idle again in cycle 2.
- R11: The request fields, `cfg_narrow` and `cfg_split` are sampled only when the request is accepted. Changing them later has no effect on the running access.
- R12: While `req_ready`=0, `req_valid` is ignored and no second access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_narrow | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| cfg_split | input | 1 | 1 = split even/odd write strobes (16-bit bus only) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_be | input | 2 | 2'b11 = word, otherwise byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block idle, request can be taken |
| resp_valid | output | 1 | Access finished (one cycle) |
| resp_err | output | 1 | Access refused as misaligned |
| resp_rdata | output | 16 | Read data |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe or even-byte write strobe |
| bus_bhe_n | output | 1 | Byte-high-enable or odd-byte write strobe |
| bus_ad_oe | output | 1 | Output enable for shared pins |
| bus_a | output | 20 | Address pins, low ones shared with data |
| bus_dh_out | output | 8 | High data byte (16-bit bus) |
| bus_sh_in | input | 9 | Read-back of shared pins bus_a[8:0] |
| bus_dh_in | input | 8 | Read-back of high data byte |

## Verification
Two functions can meet in one cycle: the configuration inputs select the strobe style, and on a narrow bus the width override forces the write/byte-high style. The bench provokes this by setting `cfg_narrow` and `cfg_split` together, both in directed writes and in seeded random traffic. It judges each data cycle on whether `bus_bhe_n` stays high and `bus_wr_n` strobes for every write. A second overlap is the sampling rule meeting a configuration change. Right after acceptance the bench flips the configuration inputs and raises a fresh request. The expected strobes and pins are still computed from the configuration that was present at acceptance.

// File: rtl/ebc_pkg.sv
// Package for the external bus controller.
// Holds the phase encoding shared by the sequencer and the top level.
package ebc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_HOLD,
        PH_DATA,
        PH_REL,
        PH_ERR
    } ebc_phase_e;
endpackage

// File: rtl/ebc_seq.sv
// Access sequencer.
// Steps through address, hold, data (DATA_CYC cycles), release, then idle.
// A refused request takes a single error cycle instead.
// Assumes start is only raised while the phase is idle.
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int DATA_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       refuse,
    output ebc_phase_e phase,
    output logic       data_last
);
    localparam int CNT_W = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;

    logic [CNT_W-1:0] left;

    // Phase register and data-cycle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            left  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) phase <= refuse ? PH_ERR : PH_ADDR;
                PH_ADDR: phase <= PH_HOLD;
                PH_HOLD: begin
                    phase <= PH_DATA;
                    left  <= CNT_W'(DATA_CYC - 1);
                end
                PH_DATA: begin
                    if (left == '0) phase <= PH_REL;
                    else            left  <= left - 1'b1;
                end
                PH_REL:  phase <= PH_IDLE;
                PH_ERR:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Marks the final strobe cycle, where read data is sampled.
    assign data_last = (phase == PH_DATA) && (left == '0);

    // R2: the data window always ends in a release cycle.
    a_r2_data_to_rel: assert property (@(posedge clk) disable iff (!rst_n)
        data_last |=> (phase == PH_REL));
endmodule

// File: rtl/ebc_lane.sv
// Strobe generator.
// Maps the access kind, the byte lanes and the strobe style onto the three strobe pins.
// Assumes its inputs are the values captured when the request was accepted.
module ebc_lane (
    input  logic narrow,
    input  logic split,
    input  logic write,
    input  logic word,
    input  logic a0,
    input  logic in_access,
    input  logic in_data,
    output logic rd_n,
    output logic wr_n,
    output logic bhe_n
);
    logic lane_lo;
    logic lane_hi;
    logic use_split;

    // Byte lanes used and the style that applies (narrow forces common strobe).
    always_comb begin
        lane_lo   = word | ~a0;
        lane_hi   = word | a0;
        use_split = split & ~narrow;
    end

    // Strobe levels for the current phase.
    always_comb begin
        rd_n = ~(in_data & ~write);
        if (use_split) begin
            wr_n  = ~(in_data & write & lane_lo);
            bhe_n = ~(in_data & write & lane_hi);
        end else begin
            wr_n  = ~(in_data & write);
            bhe_n = ~(in_access & ~narrow & lane_hi);
        end
    end
endmodule

// File: rtl/ebc_mux.sv
// Pin multiplexer.
// Places write data on the shared address pins: the low BYTE_W pins on a narrow bus,
// or those pins moved up by one on a wide bus.
// It also assembles read data from the pin read-back.
// Assumes ADDR_W > BYTE_W.
module ebc_mux #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                  narrow,
    input  logic                  drive_data,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic [BYTE_W:0]       sh_in,
    input  logic [BYTE_W-1:0]     dh_in,
    output logic [ADDR_W-1:0]     pins,
    output logic [BYTE_W-1:0]     dh_out,
    output logic [2*BYTE_W-1:0]   rd_word
);
    // One pin at a time: choose address or the data bit that map puts there.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_pin
        logic nar_bit;
        logic wid_bit;
        if (i < BYTE_W) begin : g_nar
            assign nar_bit = wdata[i];
        end else begin : g_nar_addr
            assign nar_bit = addr[i];
        end
        if (i >= 1 && i <= BYTE_W) begin : g_wid
            assign wid_bit = wdata[i-1];
        end else begin : g_wid_addr
            assign wid_bit = addr[i];
        end
        assign pins[i] = drive_data ? (narrow ? nar_bit : wid_bit) : addr[i];
    end

    // High data lane, used only on a wide bus.
    assign dh_out = (drive_data && !narrow) ? wdata[2*BYTE_W-1:BYTE_W] : '0;

    // Read word as seen on the pins for the selected width.
    assign rd_word = narrow ? {{BYTE_W{1'b0}}, sh_in[BYTE_W-1:0]}
                            : {dh_in, sh_in[BYTE_W:1]};
endmodule

// File: rtl/ext_bus_ctrl.sv
// External multiplexed bus controller, top level.
// Captures one request and its configuration at acceptance, then runs the access
// through ebc_seq, drives strobes via ebc_lane and pins via ebc_mux.
// Assumes the pads, chip selects and wait states are handled outside.
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int BYTE_W   = 8,
    parameter int DATA_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_narrow,
    input  logic                cfg_split,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_be,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                req_ready,
    output logic                resp_valid,
    output logic                resp_err,
    output logic [2*BYTE_W-1:0] resp_rdata,
    output logic                bus_ale,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    output logic                bus_bhe_n,
    output logic                bus_ad_oe,
    output logic [ADDR_W-1:0]   bus_a,
    output logic [BYTE_W-1:0]   bus_dh_out,
    input  logic [BYTE_W:0]     bus_sh_in,
    input  logic [BYTE_W-1:0]   bus_dh_in
);
    localparam int DATA_W = 2 * BYTE_W;

    ebc_phase_e        phase;
    logic              data_last;
    logic              accept;
    logic              refuse;
    logic              want_word;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_word;
    logic              write_q, narrow_q, split_q, word_q;
    logic              in_access, in_data, in_tail;

    // Acceptance and the misalignment test on the live request.
    always_comb begin
        accept    = req_valid && req_ready;
        want_word = !cfg_narrow && (req_be == 2'b11);
        refuse    = want_word && req_addr[0];
    end

    // Request and configuration capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            narrow_q <= 1'b0;
            split_q  <= 1'b0;
            word_q   <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            write_q  <= req_write;
            narrow_q <= cfg_narrow;
            split_q  <= cfg_split;
            word_q   <= want_word;
        end
    end

    ebc_seq #(.DATA_CYC(DATA_CYC)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .refuse    (refuse),
        .phase     (phase),
        .data_last (data_last)
    );

    // Phase flags and the simple outputs derived from them.
    always_comb begin
        in_access  = (phase == PH_ADDR) || (phase == PH_HOLD) ||
                     (phase == PH_DATA) || (phase == PH_REL);
        in_data    = (phase == PH_DATA);
        in_tail    = (phase == PH_DATA) || (phase == PH_REL);
        req_ready  = (phase == PH_IDLE);
        resp_valid = (phase == PH_REL) || (phase == PH_ERR);
        resp_err   = (phase == PH_ERR);
        bus_ale    = (phase == PH_ADDR);
        bus_ad_oe  = (phase == PH_ADDR) || (phase == PH_HOLD) || (in_tail && write_q);
    end

    ebc_lane lane_i (
        .narrow    (narrow_q),
        .split     (split_q),
        .write     (write_q),
        .word      (word_q),
        .a0        (addr_q[0]),
        .in_access (in_access),
        .in_data   (in_data),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .bhe_n     (bus_bhe_n)
    );

    ebc_mux #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) mux_i (
        .narrow     (narrow_q),
        .drive_data (in_tail && write_q),
        .addr       (addr_q),
        .wdata      (wdata_q),
        .sh_in      (bus_sh_in),
        .dh_in      (bus_dh_in),
        .pins       (bus_a),
        .dh_out     (bus_dh_out),
        .rd_word    (rd_word)
    );

    // Read data sample on the edge ending the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      resp_rdata <= '0;
        else if (data_last && !write_q)  resp_rdata <= rd_word;
    end

    // R2: latch enable is a one-cycle pulse.
    a_r2_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    // R3: address pins do not move across the falling latch edge.
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> $stable(bus_a));
    // R9: pins are released while the read strobe is low.
    a_r9_read_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_ad_oe && bus_wr_n));
    // R8: byte-high stays high on a narrow bus.
    a_r8_narrow_bhe: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_q && !req_ready) |-> bus_bhe_n);
    // R10: a refused request produces no bus activity.
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_valid && bus_rd_n && bus_wr_n && !bus_ale && !bus_ad_oe));
    // R12: no latch pulse starts while a response is pending.
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !bus_ale);
endmodule

// File: tb/ext_bus_ctrl_tb_top.sv
// Bench for ext_bus_ctrl: directed corner cases plus seeded random accesses,
// checked cycle by cycle against values computed from the requirements.
module ext_bus_ctrl_tb_top;
    localparam int DC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_narrow = 1'b0, cfg_split = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_valid, resp_err;
    logic [15:0] resp_rdata;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ad_oe;
    logic [19:0] bus_a;
    logic [7:0]  bus_dh_out;
    logic [8:0]  bus_sh_in = '0;
    logic [7:0]  bus_dh_in = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ext_bus_ctrl #(.ADDR_W(20), .BYTE_W(8), .DATA_CYC(DC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_split(cfg_split),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_bhe_n(bus_bhe_n), .bus_ad_oe(bus_ad_oe), .bus_a(bus_a),
        .bus_dh_out(bus_dh_out), .bus_sh_in(bus_sh_in), .bus_dh_in(bus_dh_in)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            summary();
        end
    end

    function automatic logic [35:0] observed();
        return {bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ad_oe, req_ready,
                resp_valid, resp_err, bus_a, bus_dh_out};
    endfunction

    function automatic logic [35:0] idle_vec(logic [19:0] a);
        return {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00};
    endfunction

    // Expected pins and strobes in cycle k of an accepted, aligned access.
    function automatic logic [35:0] expect_vec(int k, logic wr, logic [19:0] a,
            logic [1:0] be, logic [15:0] wd, logic nar, logic spl);
        logic word, lo, hi, dat, tail, e_rd, e_wr, e_bhe, e_oe;
        logic [19:0] p;
        logic [7:0] dh;
        word = !nar && be == 2'b11;
        lo   = word || !a[0];
        hi   = word || a[0];
        dat  = (k >= 3) && (k <= DC + 2);
        tail = (k >= 3) && (k <= DC + 3);
        e_rd = !(dat && !wr);
        if (spl && !nar) begin
            e_wr  = !(dat && wr && lo);
            e_bhe = !(dat && wr && hi);
        end else begin
            e_wr  = !(dat && wr);
            e_bhe = !(!nar && hi);
        end
        e_oe = (k <= 2) || wr;
        p  = a;
        dh = 8'h00;
        if (tail && wr) begin
            if (nar) p[7:0] = wd[7:0];
            else begin
                p[8:1] = wd[7:0];
                dh = wd[15:8];
            end
        end
        return {k == 1, e_rd, e_wr, e_bhe, e_oe, 1'b0, k == DC + 3, 1'b0, p, dh};
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Runs one access from an idle negedge; while busy, scrambles the configuration
    // and holds a junk request (R11, R12).
    task automatic run(string tag, logic wr, logic [19:0] a, logic [1:0] be,
            logic [15:0] wd, logic nar, logic spl);
        logic [8:0] rs;
        logic [7:0] rh;
        logic bad;
        rs = 9'($urandom);
        rh = 8'($urandom);
        bad = !nar && be == 2'b11 && a[0];
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be;
        req_wdata = wd; cfg_narrow = nar; cfg_split = spl;
        bus_sh_in = ~rs; bus_dh_in = ~rh;
        if (bad) begin
            @(negedge clk);
            req_valid = 1'b0;
            check("R10", observed(),
                  {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, a, 8'h00});
            @(negedge clk);
            check("R10", observed(), idle_vec(a));
            return;
        end
        for (int k = 1; k <= DC + 4; k++) begin
            @(negedge clk);
            check((k <= 2) ? "R3" : tag, observed(),
                  (k == DC + 4) ? idle_vec(a) : expect_vec(k, wr, a, be, wd, nar, spl));
            if (k == DC + 3 && !wr)
                check16("R9", resp_rdata,
                        nar ? {8'h00, rs[7:0]} : {rh, rs[8:1]});
            if (k == 1) begin
                req_write = ~wr; req_addr = 20'($urandom); req_be = 2'($urandom);
                req_wdata = 16'($urandom); cfg_narrow = ~nar; cfg_split = ~spl;
            end
            if (k == DC + 2) begin bus_sh_in = rs; bus_dh_in = rh; end
            if (k == DC + 3) begin
                req_valid = 1'b0; bus_sh_in = ~rs; bus_dh_in = ~rh;
            end
        end
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h00005eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", observed(), idle_vec(20'h0));
        @(negedge clk);
        // Directed corner cases.
        run("R4", 1'b1, 20'hA5A5A, 2'b01, 16'hC3E7, 1'b1, 1'b0);
        run("R5", 1'b1, 20'h12344, 2'b11, 16'hBEEF, 1'b0, 1'b0);
        run("R6", 1'b1, 20'h00013, 2'b10, 16'h5A00, 1'b0, 1'b0);
        run("R6", 1'b0, 20'hFFFF0, 2'b01, 16'h0000, 1'b0, 1'b0);
        run("R7", 1'b1, 20'h00020, 2'b01, 16'h0077, 1'b0, 1'b1);
        run("R7", 1'b1, 20'h00021, 2'b10, 16'h8800, 1'b0, 1'b1);
        run("R7", 1'b1, 20'h0F0F0, 2'b11, 16'h1234, 1'b0, 1'b1);
        run("R7", 1'b0, 20'h0F0F0, 2'b11, 16'h0000, 1'b0, 1'b1);
        run("R8", 1'b1, 20'h55551, 2'b11, 16'h9876, 1'b1, 1'b1);
        run("R8", 1'b0, 20'h55551, 2'b11, 16'h0000, 1'b1, 1'b1);
        run("R9", 1'b0, 20'h80006, 2'b11, 16'h0000, 1'b0, 1'b0);
        run("R10", 1'b1, 20'h00005, 2'b11, 16'hFFFF, 1'b0, 1'b1);
        run("R11", 1'b1, 20'h7777E, 2'b11, 16'hA1B2, 1'b0, 1'b1);
        run("R12", 1'b0, 20'h3C3C3, 2'b00, 16'h0000, 1'b1, 1'b0);
        // Random traffic mixing width, style, direction and alignment.
        for (int i = 0; i < 300; i++) begin
            run("R2", 1'($urandom), 20'($urandom), 2'($urandom), 16'($urandom),
                1'($urandom), 1'($urandom));
        end
        summary();
    end
endmodule